// File: doc/BRIEF.md
# Configurable Serial Line Codec

This block turns a stream of data bits into a two-level line waveform and recovers the bits from such a waveform. Eight line codes share one datapath: level coding, inverted level coding, two transition-based codes (toggle on a one, toggle on a zero) and four split-cell codes (two frequency-modulation variants, Manchester and differential Manchester). Bit-cell timing is supplied from outside as strobes, so the block has no clock recovery of its own.

The transmitter takes one bit with a cell-start strobe and drives the level for the first half of the cell. On a mid-cell strobe it drives the level for the second half. The receiver takes one line sample on a first-half strobe and another on a second-half strobe. From those two samples and the level that ended the previous cell, it produces the data bit and a code-violation flag. The code is chosen by a 3-bit select that is captured only while `run` is low. While `run` is high the captured code is frozen.

The transmit state machine has the states TX_IDLE, TX_FIRST and TX_SECOND. It moves to TX_FIRST on a cell strobe while running, from any state. It moves from TX_FIRST to TX_SECOND on a mid-cell strobe, and back to TX_IDLE whenever `run` is low. The receive state machine has the states RX_IDLE and RX_WAIT_SECOND. It moves to RX_WAIT_SECOND on a first-sample strobe while running. It returns to RX_IDLE on a second-sample strobe, where it emits a bit, or when `run` drops.

Top module: `serial_line_codec`

## Requirements
- R1: After reset `line_out` is 0, `rx_valid` and `rx_viol` are 0, the captured code is 0, and the receiver's previous-cell level is 0.
- R2: `enc_sel` is captured into the active code on every clock edge where `run` is low. Changes of `enc_sel` while `run` is high have no effect on the line or the decoding. The code values are 0 level, 1 inverted level, 2 toggle-on-one, 3 toggle-on-zero, 4 split-cell toggle-mid-on-one, 5 split-cell toggle-mid-on-zero, 6 Manchester and 7 differential Manchester.
- R3: Code 0 drives the whole cell high for a 1 and low for a 0. Code 1 drives it low for a 1 and high for a 0.
- R4: Code 2 inverts the line at cell start for a 1 and keeps it for a 0. Code 3 inverts it for a 0 and keeps it for a 1. Neither code changes the line at mid-cell.
- R5: Codes 4 and 5 always invert the line at cell start. At mid-cell, code 4 inverts it again only for a 1, and code 5 only for a 0.
- R6: Code 6 drives the first half high for a 1 and low for a 0. Code 7 inverts at cell start for a 1 and keeps the level for a 0. Both codes always invert at mid-cell.
- R7: `line_out` changes only in the cycle after a clock edge where `run` was high together with `tx_cell_stb`, or together with `tx_half_stb` in TX_FIRST. Strobes while `run` is low, and a mid-cell strobe outside TX_FIRST, leave the line unchanged.
- R8: One cycle after an edge with `run` and `rx_second_stb` in RX_WAIT_SECOND, `rx_valid` is high for one cycle and `rx_bit` holds the bit that the active code maps to the two samples and the previous-cell level.
- R9: With `rx_valid`, `rx_viol` is 1 when a code 4 or 5 cell's first sample equals the previous-cell level, or when a code 6 or 7 cell's two samples are equal. It is 0 for codes 0 to 3.
- R10: The first cell after reset is coded relative to a low line. For example, a 0 in code 3 drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables coding; low captures `enc_sel` |
| enc_sel | input | 3 | Line code select |
| tx_bit | input | 1 | Data bit, taken with `tx_cell_stb` |
| tx_cell_stb | input | 1 | Transmit cell-start strobe |
| tx_half_stb | input | 1 | Transmit mid-cell strobe |
| line_out | output | 1 | Coded line level |
| rx_line | input | 1 | Received line level |
| rx_first_stb | input | 1 | Sample the first half of a received cell |
| rx_second_stb | input | 1 | Sample the second half and decode |
| rx_bit | output | 1 | Recovered data bit |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` and `rx_viol` are new |
| rx_viol | output | 1 | Code violation in the decoded cell |

## Verification
A wrong encoder level or a wrong stored line level shows on `line_out` one cycle after the strobe that caused it. Because the toggle-based codes carry the level forward, the error then persists into every later cell. A wrong receiver previous-cell level corrupts `rx_bit` or raises a false `rx_viol` on the very next decoded cell, which appears one cycle after the second-sample strobe. A code captured while running would flip the first cell that follows.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        ENC_NRZ    = 3'd0,
        ENC_NRZB   = 3'd1,
        ENC_NRZI_M = 3'd2,
        ENC_NRZI_S = 3'd3,
        ENC_FM1    = 3'd4,
        ENC_FM0    = 3'd5,
        ENC_MANCH  = 3'd6,
        ENC_DMANCH = 3'd7
    } enc_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_FIRST  = 2'd1,
        TX_SECOND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE        = 1'b0,
        RX_WAIT_SECOND = 1'b1
    } rx_state_e;

    // Level for the first half of a cell, from the bit and the level that ended the last cell
    function automatic logic first_level(enc_e m, logic b, logic last);
        logic r;
        unique case (m)
            ENC_NRZ:    r = b;
            ENC_NRZB:   r = ~b;
            ENC_NRZI_M: r = last ^ b;
            ENC_NRZI_S: r = last ^ ~b;
            ENC_FM1:    r = ~last;
            ENC_FM0:    r = ~last;
            ENC_MANCH:  r = b;
            ENC_DMANCH: r = last ^ b;
            default:    r = b;
        endcase
        return r;
    endfunction

    // Level for the second half, from the bit and the first-half level
    function automatic logic second_level(enc_e m, logic b, logic first);
        logic r;
        unique case (m)
            ENC_FM1:    r = first ^ b;
            ENC_FM0:    r = first ^ ~b;
            ENC_MANCH:  r = ~first;
            ENC_DMANCH: r = ~first;
            default:    r = first;
        endcase
        return r;
    endfunction

    function automatic logic decode_bit(enc_e m, logic prev, logic a, logic b);
        logic r;
        unique case (m)
            ENC_NRZ:    r = b;
            ENC_NRZB:   r = ~b;
            ENC_NRZI_M: r = b ^ prev;
            ENC_NRZI_S: r = ~(b ^ prev);
            ENC_FM1:    r = a ^ b;
            ENC_FM0:    r = ~(a ^ b);
            ENC_MANCH:  r = a;
            ENC_DMANCH: r = a ^ prev;
            default:    r = b;
        endcase
        return r;
    endfunction

    function automatic logic decode_viol(enc_e m, logic prev, logic a, logic b);
        logic r;
        unique case (m)
            ENC_FM1, ENC_FM0:      r = (a == prev);
            ENC_MANCH, ENC_DMANCH: r = (a == b);
            default:               r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/slc_mode_latch.sv
module slc_mode_latch
    import slc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel_in,
    output enc_e             mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= ENC_NRZ;
        end else if (!run) begin
            mode_q <= enc_e'(sel_in);
        end
    end
endmodule

// File: rtl/slc_tx_encoder.sv
module slc_tx_encoder
    import slc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  enc_e      mode,
    input  logic      tx_bit,
    input  logic      cell_stb,
    input  logic      half_stb,
    output logic      line_q,
    output tx_state_e state_q
);
    tx_state_e state_d;
    logic      bit_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (run && cell_stb) state_d = TX_FIRST;
            end
            TX_FIRST: begin
                if (!run)          state_d = TX_IDLE;
                else if (cell_stb) state_d = TX_FIRST;
                else if (half_stb) state_d = TX_SECOND;
            end
            TX_SECOND: begin
                if (!run)          state_d = TX_IDLE;
                else if (cell_stb) state_d = TX_FIRST;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            bit_q  <= 1'b0;
        end else if (run && cell_stb) begin
            line_q <= first_level(mode, tx_bit, line_q);
            bit_q  <= tx_bit;
        end else if (run && half_stb && state_q == TX_FIRST) begin
            line_q <= second_level(mode, bit_q, line_q);
        end
    end
endmodule

// File: rtl/slc_rx_decoder.sv
module slc_rx_decoder
    import slc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  enc_e mode,
    input  logic rx_line,
    input  logic first_stb,
    input  logic second_stb,
    output logic rx_bit,
    output logic rx_valid,
    output logic rx_viol
);
    rx_state_e state_q, state_d;
    logic      first_q;
    logic      prev_q;
    logic      take;

    assign take = run && second_stb && (state_q == RX_WAIT_SECOND);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (run && first_stb) state_d = RX_WAIT_SECOND;
            end
            RX_WAIT_SECOND: begin
                if (!run)            state_d = RX_IDLE;
                else if (second_stb) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b0;
            prev_q   <= 1'b0;
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
            rx_viol  <= 1'b0;
        end else begin
            rx_valid <= take;
            rx_viol  <= take && decode_viol(mode, prev_q, first_q, rx_line);
            if (run && first_stb && state_q == RX_IDLE) begin
                first_q <= rx_line;
            end
            if (take) begin
                rx_bit <= decode_bit(mode, prev_q, first_q, rx_line);
                prev_q <= rx_line;
            end
        end
    end
endmodule

// File: rtl/serial_line_codec.sv
module serial_line_codec
    import slc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] enc_sel,
    input  logic       tx_bit,
    input  logic       tx_cell_stb,
    input  logic       tx_half_stb,
    output logic       line_out,
    input  logic       rx_line,
    input  logic       rx_first_stb,
    input  logic       rx_second_stb,
    output logic       rx_bit,
    output logic       rx_valid,
    output logic       rx_viol
);
    enc_e      mode_q;
    tx_state_e tx_state;

    slc_mode_latch mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sel_in (enc_sel),
        .mode_q (mode_q)
    );

    slc_tx_encoder tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mode     (mode_q),
        .tx_bit   (tx_bit),
        .cell_stb (tx_cell_stb),
        .half_stb (tx_half_stb),
        .line_q   (line_out),
        .state_q  (tx_state)
    );

    slc_rx_decoder rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mode       (mode_q),
        .rx_line    (rx_line),
        .first_stb  (rx_first_stb),
        .second_stb (rx_second_stb),
        .rx_bit     (rx_bit),
        .rx_valid   (rx_valid),
        .rx_viol    (rx_viol)
    );
endmodule

// File: rtl/slc_checker.sv
module slc_checker
    import slc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      run,
    input logic      tx_cell_stb,
    input logic      tx_half_stb,
    input logic      rx_second_stb,
    input logic      line_out,
    input logic      rx_valid,
    input logic      rx_viol,
    input enc_e      mode_q,
    input tx_state_e tx_state
);
    // R7
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_out) |-> $past(run && (tx_cell_stb || tx_half_stb)));

    // R8
    rx_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(run && rx_second_stb));

    // R9
    viol_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_viol |-> (rx_valid && mode_q[2]));

    // R5
    fm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_cell_stb && (mode_q == ENC_FM1 || mode_q == ENC_FM0))
        |=> (line_out != $past(line_out)));

    // R6
    manch_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_half_stb && !tx_cell_stb && tx_state == TX_FIRST &&
         (mode_q == ENC_MANCH || mode_q == ENC_DMANCH))
        |=> (line_out != $past(line_out)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(mode_q));
endmodule

bind serial_line_codec slc_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .tx_cell_stb   (tx_cell_stb),
    .tx_half_stb   (tx_half_stb),
    .rx_second_stb (rx_second_stb),
    .line_out      (line_out),
    .rx_valid      (rx_valid),
    .rx_viol       (rx_viol),
    .mode_q        (mode_q),
    .tx_state      (tx_state)
);

// File: tb/serial_line_codec_tb_top.sv
module serial_line_codec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] enc_sel = 3'd0;
    logic       tx_bit = 1'b0;
    logic       tx_cell_stb = 1'b0;
    logic       tx_half_stb = 1'b0;
    logic       line_out;
    logic       rx_line;
    logic       rx_first_stb = 1'b0;
    logic       rx_second_stb = 1'b0;
    logic       rx_bit;
    logic       rx_valid;
    logic       rx_viol;
    logic       ext_en = 1'b0;
    logic       ext_line = 1'b0;

    int  n_tests = 0;
    int  n_fail = 0;
    logic lvl = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    assign rx_line = ext_en ? ext_line : line_out;

    serial_line_codec dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .enc_sel       (enc_sel),
        .tx_bit        (tx_bit),
        .tx_cell_stb   (tx_cell_stb),
        .tx_half_stb   (tx_half_stb),
        .line_out      (line_out),
        .rx_line       (rx_line),
        .rx_first_stb  (rx_first_stb),
        .rx_second_stb (rx_second_stb),
        .rx_bit        (rx_bit),
        .rx_valid      (rx_valid),
        .rx_viol       (rx_viol)
    );

    function automatic logic exp_first(int m, logic b, logic l);
        case (m)
            0: return b;
            1: return ~b;
            2: return b ? ~l : l;
            3: return b ? l : ~l;
            4, 5: return ~l;
            6: return b;
            default: return b ? ~l : l;
        endcase
    endfunction

    function automatic logic exp_second(int m, logic b, logic f);
        case (m)
            4: return b ? ~f : f;
            5: return b ? f : ~f;
            6, 7: return ~f;
            default: return f;
        endcase
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic set_mode(int m);
        @(negedge clk) run = 1'b0; enc_sel = 3'(m);
        @(negedge clk) run = 1'b1;
    endtask

    // One full cell through the loopback, with checks on both halves and the decode
    task automatic do_cell(int m, logic b, string req);
        logic f, s;
        f = exp_first(m, b, lvl);
        s = exp_second(m, b, f);
        tx_bit = b;
        pulse(tx_cell_stb);
        check(line_out == f, req, line_out, f);
        pulse(rx_first_stb);
        pulse(tx_half_stb);
        check(line_out == s, req, line_out, s);
        pulse(rx_second_stb);
        check(rx_valid == 1'b1, "R8 valid", rx_valid, 1);
        check(rx_bit == b, "R8 bit", rx_bit, b);
        check(rx_viol == 1'b0, "R9 clean", rx_viol, 0);
        lvl = s;
    endtask

    task automatic ext_cell(logic a, logic b, logic eb, logic ev, string req);
        ext_line = a;
        pulse(rx_first_stb);
        ext_line = b;
        pulse(rx_second_stb);
        check(rx_valid == 1'b1, req, rx_valid, 1);
        check(rx_bit == eb, req, rx_bit, eb);
        check(rx_viol == ev, req, rx_viol, ev);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic hold;
        repeat (3) @(negedge clk);
        check(line_out == 1'b0, "R1 line", line_out, 0);
        check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        check(rx_viol == 1'b0, "R1 viol", rx_viol, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: toggle-on-zero from the reset level
        set_mode(3);
        do_cell(3, 1'b0, "R10 first cell");

        // Sweep every code over a varied bit pattern (R3 R4 R5 R6)
        for (int m = 0; m < 8; m++) begin
            set_mode(m);
            for (int k = 0; k < 16; k++) begin
                logic b;
                b = 1'(((k * 5 + m * 3) >> 1) ^ (k >> 3));
                do_cell(m, b, m < 2 ? "R3 level" : m < 4 ? "R4 nrzi" :
                              m < 6 ? "R5 fm" : "R6 manch");
            end
        end

        // R2: select change while running has no effect
        set_mode(0);
        @(negedge clk) enc_sel = 3'd1;
        do_cell(0, 1'b1, "R2 select frozen");
        do_cell(0, 1'b0, "R2 select frozen");

        // R7: strobes while stopped are ignored
        @(negedge clk) run = 1'b0; enc_sel = 3'd4;
        hold = line_out;
        tx_bit = 1'b1;
        pulse(tx_cell_stb);
        pulse(tx_half_stb);
        check(line_out == hold, "R7 stopped", line_out, hold);
        pulse(rx_second_stb);
        check(rx_valid == 1'b0, "R8 stopped", rx_valid, 0);
        @(negedge clk) run = 1'b1;

        // R7: a second mid-cell strobe is ignored
        do_cell(4, 1'b1, "R5 fm");
        hold = line_out;
        pulse(tx_half_stb);
        check(line_out == hold, "R7 extra half", line_out, hold);

        // R9: violations on an externally driven line
        @(negedge clk) ext_en = 1'b1;
        set_mode(6);
        ext_cell(1'b1, 1'b1, 1'b1, 1'b1, "R9 manch no mid");
        ext_cell(1'b1, 1'b0, 1'b1, 1'b0, "R9 manch good");
        set_mode(4);
        ext_cell(1'b0, 1'b1, 1'b1, 1'b1, "R9 fm no start");
        set_mode(5);
        ext_cell(1'b0, 1'b1, 1'b0, 1'b0, "R9 fm0 good");
        set_mode(0);
        ext_cell(1'b1, 1'b1, 1'b1, 1'b0, "R9 level none");
        @(negedge clk);
        check(rx_valid == 1'b0, "R8 pulse", rx_valid, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule